// File: doc/BRIEF.md
# Oscillator Power Sequencer

This block turns a low-power on-chip oscillator on and off in a fixed order. It drives three control lines toward the oscillator: enable, reset and clock-gate-enable. It waits a fixed time between steps. Waits are counted in cycles of the reference clock. Their lengths are worked out at elaboration time from the reference frequency parameter `REF_KHZ`, as ceil(microseconds × kHz / 1000).

A requester presents a clock-source code together with an operation bit (1 = bring up, 0 = tear down). The block takes the request on a rising edge where `req_valid` is high and `busy` is low. Only the codes that derive from the oscillator start a sequence. Power-up requests with a selectable code also update the source-select output. When the work for a request is finished, the block answers with a one-cycle acknowledge.

Top module: `osc_pwrseq`

## Requirements
- R1: While `rst_n` is low, `osc_en`, `osc_rst`, `osc_gate`, `osc_running`, `req_ack` and `busy` are 0 and `src_sel` is 4 (bypass).
- R2: An accepted bring-up with an oscillator code sets `osc_en` after the accepting edge. `osc_rst` rises T_EN cycles later and stays high for T_RST cycles. `osc_gate` rises T_SETTLE cycles after `osc_rst` falls. T_EN = ceil(11·f), T_RST = ceil(40·f) and T_SETTLE = ceil(130·f), where f is `REF_KHZ`/1000.
- R3: An accepted tear-down with an oscillator code clears `osc_gate` after the accepting edge. It clears `osc_en` T_RST cycles later. `osc_rst` stays 0 throughout.
- R4: `osc_running` is 1 exactly when `osc_en` and `osc_gate` are both 1.
- R5: Only codes 0, 1, 5 and 6 start a sequence. Codes 2, 3, 4 and 7 complete with an acknowledge in the next cycle and leave `osc_en`, `osc_rst` and `osc_gate` unchanged.
- R6: An accepted bring-up whose code is 0, 1, 2, 3, 5 or 6 loads that code into `src_sel` after the accepting edge. Codes 4 and 7, and every tear-down, leave `src_sel` unchanged.
- R7: `req_ack` is high for exactly one cycle. It comes on the same edge as the last control-line change of the sequence. `busy` is high from the accepting edge through the acknowledge cycle.
- R8: A request presented while `busy` is high is ignored and changes no output.
- R9: A bring-up while `osc_running` is 1, or a tear-down while `osc_en` and `osc_gate` are both 0, acknowledges in the next cycle and changes no control line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_on | input | 1 | 1 = bring up, 0 = tear down |
| req_code | input | 3 | Clock-source code |
| req_ack | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Request in progress, new requests ignored |
| osc_en | output | 1 | Oscillator enable |
| osc_rst | output | 1 | Oscillator reset |
| osc_gate | output | 1 | Oscillator clock-gate-enable |
| osc_running | output | 1 | Oscillator reads as on |
| src_sel | output | 3 | Selected clock source code |

## Verification
Two events can fall in the same cycle: a new request and the completion of the previous one. A request arriving in the acknowledge cycle must still be ignored. A request arriving in the first cycle after the acknowledge must be taken. Random request gaps of zero to three cycles are mixed with waits for idle, so new requests land on the ack cycle, inside sequences and just after them. A cycle-by-cycle bench model, built from the timing in the requirements, judges every output on every cycle.

// File: rtl/osc_pwrseq_pkg.sv
package osc_pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_UP_EN   = 3'd1,
    ST_UP_RST  = 3'd2,
    ST_UP_SETL = 3'd3,
    ST_DN_GATE = 3'd4
  } seq_state_e;

  localparam logic [2:0] SRC_BYPASS = 3'd4;

  // ceil(us * kHz / 1000) reference cycles
  function automatic int unsigned us_to_cycles(input int unsigned us,
                                               input int unsigned khz);
    return (us * khz + 999) / 1000;
  endfunction

endpackage

// File: rtl/osc_src_decode.sv
module osc_src_decode #(
  parameter int CODE_W = 3
) (
  input  logic [CODE_W-1:0] code,
  output logic              uses_osc,
  output logic              selectable
);
  always_comb begin
    uses_osc   = 1'b0;
    selectable = 1'b0;
    case (code)
      CODE_W'(0), CODE_W'(1), CODE_W'(5), CODE_W'(6): begin
        uses_osc   = 1'b1;
        selectable = 1'b1;
      end
      CODE_W'(2), CODE_W'(3): selectable = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/osc_wait_timer.sv
module osc_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en  = clr | run;
  assign cnt_d   = clr ? '0 : cnt_q + 1'b1;
  assign expired = (cnt_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/osc_seq_ctrl.sv
module osc_seq_ctrl
  import osc_pwrseq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int T_EN     = 11,
  parameter int T_RST    = 40,
  parameter int T_SETTLE = 130
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             op_on,
  input  logic             uses_osc,
  input  logic             expired,
  output logic             timer_clr,
  output logic             timer_run,
  output logic [CNT_W-1:0] limit,
  output logic             en,
  output logic             rst,
  output logic             gate,
  output logic             ack,
  output logic             busy
);
  seq_state_e st_q, st_d;
  logic en_q, en_d, rst_q, rst_d, gate_q, gate_d, ack_q, ack_d;

  always_comb begin
    st_d      = st_q;
    en_d      = en_q;
    rst_d     = rst_q;
    gate_d    = gate_q;
    ack_d     = 1'b0;
    timer_clr = 1'b0;
    case (st_q)
      ST_IDLE: if (accept) begin
        if (!uses_osc) begin
          ack_d = 1'b1;
        end else if (op_on) begin
          if (en_q && gate_q) begin
            ack_d = 1'b1;
          end else begin
            en_d      = 1'b1;
            st_d      = ST_UP_EN;
            timer_clr = 1'b1;
          end
        end else begin
          if (!en_q && !gate_q) begin
            ack_d = 1'b1;
          end else begin
            gate_d    = 1'b0;
            st_d      = ST_DN_GATE;
            timer_clr = 1'b1;
          end
        end
      end
      ST_UP_EN: if (expired) begin
        rst_d     = 1'b1;
        st_d      = ST_UP_RST;
        timer_clr = 1'b1;
      end
      ST_UP_RST: if (expired) begin
        rst_d     = 1'b0;
        st_d      = ST_UP_SETL;
        timer_clr = 1'b1;
      end
      ST_UP_SETL: if (expired) begin
        gate_d = 1'b1;
        ack_d  = 1'b1;
        st_d   = ST_IDLE;
      end
      ST_DN_GATE: if (expired) begin
        en_d  = 1'b0;
        ack_d = 1'b1;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (st_q)
      ST_UP_EN:   limit = CNT_W'(T_EN);
      ST_UP_RST:  limit = CNT_W'(T_RST);
      ST_UP_SETL: limit = CNT_W'(T_SETTLE);
      default:    limit = CNT_W'(T_RST);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      en_q   <= 1'b0;
      rst_q  <= 1'b0;
      gate_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      en_q   <= en_d;
      rst_q  <= rst_d;
      gate_q <= gate_d;
      ack_q  <= ack_d;
    end
  end

  assign timer_run = (st_q != ST_IDLE);
  assign en        = en_q;
  assign rst       = rst_q;
  assign gate      = gate_q;
  assign ack       = ack_q;
  assign busy      = (st_q != ST_IDLE) | ack_q;
endmodule

// File: rtl/osc_pwrseq.sv
module osc_pwrseq
  import osc_pwrseq_pkg::*;
#(
  parameter int REF_KHZ = 26000,
  parameter int CODE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_on,
  input  logic [CODE_W-1:0] req_code,
  output logic              req_ack,
  output logic              busy,
  output logic              osc_en,
  output logic              osc_rst,
  output logic              osc_gate,
  output logic              osc_running,
  output logic [CODE_W-1:0] src_sel
);
  localparam int T_EN     = int'(us_to_cycles(11,  REF_KHZ));
  localparam int T_RST    = int'(us_to_cycles(40,  REF_KHZ));
  localparam int T_SETTLE = int'(us_to_cycles(130, REF_KHZ));
  localparam int CNT_W    = $clog2(T_SETTLE + 2);

  logic             uses_osc, selectable, accept, expired;
  logic             timer_clr, timer_run;
  logic [CNT_W-1:0] limit;
  logic             sel_load;
  logic [CODE_W-1:0] sel_q;

  assign accept = req_valid & ~busy;

  osc_src_decode #(.CODE_W(CODE_W)) u_dec (
    .code       (req_code),
    .uses_osc   (uses_osc),
    .selectable (selectable)
  );

  osc_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (timer_clr),
    .run     (timer_run),
    .limit   (limit),
    .expired (expired)
  );

  osc_seq_ctrl #(
    .CNT_W    (CNT_W),
    .T_EN     (T_EN),
    .T_RST    (T_RST),
    .T_SETTLE (T_SETTLE)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .op_on     (req_on),
    .uses_osc  (uses_osc),
    .expired   (expired),
    .timer_clr (timer_clr),
    .timer_run (timer_run),
    .limit     (limit),
    .en        (osc_en),
    .rst       (osc_rst),
    .gate      (osc_gate),
    .ack       (req_ack),
    .busy      (busy)
  );

  assign sel_load = accept & req_on & selectable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_q <= CODE_W'(SRC_BYPASS);
    else if (sel_load) sel_q <= req_code;
  end

  assign src_sel     = sel_q;
  assign osc_running = osc_en & osc_gate;
endmodule

// File: rtl/osc_pwrseq_chk.sv
module osc_pwrseq_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_on,
  input logic [CODE_W-1:0] req_code,
  input logic              req_ack,
  input logic              busy,
  input logic              osc_en,
  input logic              osc_rst,
  input logic              osc_gate,
  input logic              osc_running,
  input logic [CODE_W-1:0] src_sel
);
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);                                   // R7
  AST_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> busy);                                       // R7
  AST_RST_UNDER_EN: assert property (@(posedge clk) disable iff (!rst_n)
    osc_rst |-> (osc_en && !osc_gate));                      // R2
  AST_GATE_UNDER_EN: assert property (@(posedge clk) disable iff (!rst_n)
    osc_gate |-> osc_en);                                    // R3
  AST_GATE_RISE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_gate) |-> req_ack);                            // R2
  AST_EN_FALL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> (req_ack && !osc_gate && !osc_rst));   // R3
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(src_sel));               // R8
  AST_BYPASS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && (req_code == CODE_W'(4) || req_code == CODE_W'(7)))
      |=> $stable(src_sel));                                 // R6
  AST_RUNNING_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    osc_running |-> (osc_en && osc_gate));                   // R4
endmodule

bind osc_pwrseq osc_pwrseq_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/osc_pwrseq_test.sv
module osc_pwrseq_test;
  localparam int KHZ = 1000;
  localparam int T1 = (11 * KHZ + 999) / 1000;
  localparam int T2 = (40 * KHZ + 999) / 1000;
  localparam int T3 = (130 * KHZ + 999) / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_on = 1'b0;
  logic [2:0] req_code = 3'd0;
  logic req_ack, busy, osc_en, osc_rst, osc_gate, osc_running;
  logic [2:0] src_sel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  osc_pwrseq #(.REF_KHZ(KHZ), .CODE_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on),
    .req_code(req_code), .req_ack(req_ack), .busy(busy), .osc_en(osc_en),
    .osc_rst(osc_rst), .osc_gate(osc_gate), .osc_running(osc_running),
    .src_sel(src_sel)
  );

  function automatic bit f_uses(input logic [2:0] c);
    return (c == 3'd0 || c == 3'd1 || c == 3'd5 || c == 3'd6);
  endfunction
  function automatic bit f_sel(input logic [2:0] c);
    return f_uses(c) || c == 3'd2 || c == 3'd3;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model, advanced on each rising edge
  int  m_ph = 0;
  int  m_t = 0;
  bit  m_en, m_rst, m_gate, m_ack;
  logic [2:0] m_sel = 3'd4;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_t = 0; m_en = 0; m_rst = 0; m_gate = 0; m_ack = 0; m_sel = 3'd4;
    end else begin
      bit acc;
      acc = req_valid && !((m_ph != 0) || m_ack);
      m_ack = 0;
      if (m_ph == 0) begin
        if (acc) begin
          if (req_on && f_sel(req_code)) m_sel = req_code;
          if (!f_uses(req_code)) m_ack = 1;
          else if (req_on) begin
            if (m_en && m_gate) m_ack = 1;
            else begin m_en = 1; m_ph = 1; m_t = 0; end
          end else begin
            if (!m_en && !m_gate) m_ack = 1;
            else begin m_gate = 0; m_ph = 2; m_t = 0; end
          end
        end
      end else if (m_ph == 1) begin
        m_t++;
        if (m_t == T1) m_rst = 1;
        if (m_t == T1 + T2) m_rst = 0;
        if (m_t == T1 + T2 + T3) begin m_gate = 1; m_ack = 1; m_ph = 0; end
      end else begin
        m_t++;
        if (m_t == T2) begin m_en = 0; m_ack = 1; m_ph = 0; end
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk("R2 R3 osc_en", osc_en, m_en);
      chk("R2 R3 osc_rst", osc_rst, m_rst);
      chk("R2 R3 osc_gate", osc_gate, m_gate);
      chk("R4 osc_running", osc_running, m_en && m_gate);
      chk("R7 req_ack", req_ack, m_ack);
      chk("R7 busy", busy, (m_ph != 0) || m_ack);
      chk("R6 src_sel", src_sel, m_sel);
    end
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic issue(input bit on, input logic [2:0] code);
    @(negedge clk);
    req_valid = 1'b1; req_on = on; req_code = code;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 osc_en", osc_en, 0);
    chk("R1 osc_rst", osc_rst, 0);
    chk("R1 osc_gate", osc_gate, 0);
    chk("R1 busy", busy, 0);
    chk("R1 req_ack", req_ack, 0);
    chk("R1 src_sel", src_sel, 4);
    rst_n = 1'b1;
    @(negedge clk);

    issue(1'b1, 3'd3);                // non-oscillator code
    chk("R5 ack code3", req_ack, 1);
    chk("R5 en code3", osc_en, 0);
    chk("R6 sel code3", src_sel, 3);
    wait_idle();
    issue(1'b1, 3'd4);                // bypass
    chk("R6 sel bypass kept", src_sel, 3);
    chk("R5 ack bypass", req_ack, 1);
    wait_idle();
    issue(1'b0, 3'd1);                // tear-down while off
    chk("R9 ack off", req_ack, 1);
    chk("R9 en off", osc_en, 0);
    wait_idle();
    issue(1'b1, 3'd5);                // full bring-up
    chk("R2 en first", osc_en, 1);
    chk("R2 rst not yet", osc_rst, 0);
    chk("R7 busy", busy, 1);
    issue(1'b1, 3'd2);                // ignored while busy
    chk("R8 sel unchanged", src_sel, 5);
    wait_idle();
    chk("R4 running", osc_running, 1);
    issue(1'b1, 3'd0);                // bring-up while on
    chk("R9 ack on", req_ack, 1);
    chk("R9 running kept", osc_running, 1);
    wait_idle();
    issue(1'b0, 3'd6);                // tear-down
    chk("R3 gate first", osc_gate, 0);
    chk("R3 en held", osc_en, 1);
    wait_idle();
    chk("R3 en cleared", osc_en, 0);
    chk("R3 rst untouched", osc_rst, 0);

    for (int i = 0; i < 150; i++) begin
      issue(1'($urandom % 2), 3'($urandom % 8));
      if ($urandom % 2 == 0) wait_idle();
      else repeat ($urandom % 4) @(negedge clk);
    end
    wait_idle();
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule